// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours, day-of-week, date, month and a two-digit year. It advances by exactly one second for each pulse on a one-second tick input. Logic outside the block derives that pulse from a crystal or from a 50/60 Hz line input. The hours register runs either as a 24-hour count or as a 12-hour count with an AM/PM flag. The calendar covers months of 28, 29, 30 and 31 days and gives February 29 days in every year divisible by four.

A host reaches the registers through a plain register port: a write strobe with address and data, and a read data output that follows the address combinationally. To read a consistent snapshot across several registers, the host holds the freeze input high. The registers then stop changing. Ticks that arrive in the meantime are counted and are applied one per cycle once freeze is released, so no second is lost. An alarm compares seconds, minutes and hours with three alarm registers. It pulses an output when the time steps onto the alarm value.

All pins are plain control and status signals. There is no streaming data path, so the port has no valid/ready handshake and no back-pressure: a write is taken in the cycle its strobe is high, and read data is valid in the same cycle as its address.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 8'h00, day-of-week reads 8'h01, date and month read 8'h01, the alarm registers and the control register read 8'h00, and alarm_o is low.
- R2: Each advance increments seconds in BCD from 8'h00 to 8'h59; 8'h59 wraps to 8'h00 and increments minutes, which wrap the same way and carry into hours. A tick sampled high, with freeze and write low, shows its new value at the next rising clock edge.
- R3: With control bit 0 clear (24-hour mode), hours count 8'h00 to 8'h23, and 8'h23 wraps to 8'h00 and carries into the day.
- R4: With control bit 0 set (12-hour mode), hours bits 4:0 hold BCD 01 to 12 and bit 5 is the PM flag. The sequence is 12, 01, ... 11, 12. The flag toggles on the step from 11 to 12, and only the step from 11 PM to 12 AM carries into the day.
- R5: Day-of-week counts 1 to 7 and wraps from 7 to 1 on each day carry.
- R6: Date wraps to 8'h01 after the last day of the month: 31 for months 01, 03, 05, 07, 08, 10, 12; 30 for 04, 06, 09, 11; 28 for February in other years. Month wraps from 8'h12 to 8'h01 and carries into the year, which wraps from 8'h99 to 8'h00.
- R7: February has 29 days when the BCD year is divisible by four (00, 04 ... 96).
- R8: While freeze_i is high, no register changes on a tick. Each such tick is held as pending, up to 15. When freeze_i is low, one pending second is applied per cycle until none remain.
- R9: wr_en_i writes wdata_i to the register at addr_i at the clock edge. No advance takes place in a write cycle; a tick in that cycle is held as pending. Address map: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year, 8 alarm seconds, 9 alarm minutes, 10 alarm hours, 11 control (only bit 0 is kept).
- R10: alarm_o is high for exactly the one cycle in which the registers first show, after an advance, seconds, minutes and hours (all 8 bits, including the PM flag) equal to the three alarm registers.
- R11: rdata_o shows the register at addr_i in the same cycle. Unmapped addresses (7, 12 to 15) read 8'h00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| freeze_i | input | 1 | Holds all registers stable while high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| alarm_o | output | 1 | One-cycle alarm pulse |

## Verification
A tick or write sampled at one rising edge shows in the registers and on alarm_o right after that edge. A pending tick that a freeze or a write held back shows one edge later for each second still queued ahead of it. Read data is combinational, so it is due in the same cycle as its address. The bench drives inputs just after each rising edge. It updates a behavioural model at the same edge and compares rdata_o and alarm_o against the model at every falling edge, so every result is sampled in the cycle it is due. Directed reads at named boundaries land on those same falling edges.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_time_t;

  localparam logic [3:0] A_SEC   = 4'd0;
  localparam logic [3:0] A_MIN   = 4'd1;
  localparam logic [3:0] A_HOUR  = 4'd2;
  localparam logic [3:0] A_DOW   = 4'd3;
  localparam logic [3:0] A_DATE  = 4'd4;
  localparam logic [3:0] A_MONTH = 4'd5;
  localparam logic [3:0] A_YEAR  = 4'd6;
  localparam logic [3:0] A_ASEC  = 4'd8;
  localparam logic [3:0] A_AMIN  = 4'd9;
  localparam logic [3:0] A_AHOUR = 4'd10;
  localparam logic [3:0] A_CTRL  = 4'd11;

  // Two-digit BCD increment without range check
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year divisible by four, decided digit-wise: even tens need 0/4/8, odd tens need 2/6
  function automatic logic leap_year(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  // Last date of a month, in BCD
  function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_tick_gate.sv
module cal_tick_gate
  import cal_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic freeze_i,
  input  logic hold_i,
  output logic step_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend_q;
  logic              have_pend;

  assign have_pend = (pend_q != '0);
  assign step_o    = !freeze_i && !hold_i && (tick_i || have_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (tick_i && !step_o) begin
      if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
    end else if (!tick_i && step_o) begin
      pend_q <= pend_q - 1'b1;
    end
  end

  // R8: a held-back tick always leaves something to apply later
  a_r8_tick_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && freeze_i) |=> (pend_q != '0));

  // R8: released with work pending, an advance is issued
  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_i && !hold_i && pend_q != '0) |-> step_o);

endmodule

// File: rtl/cal_time_step.sv
module cal_time_step
  import cal_pkg::*;
(
  input  cal_time_t cur_i,
  input  logic      mode12_i,
  output cal_time_t nxt_o
);
  logic       c_min, c_hour, c_day, c_month, c_year;
  logic [4:0] h12;
  logic       pm;
  logic [7:0] h12_inc;

  assign h12     = cur_i.hour[4:0];
  assign pm      = cur_i.hour[5];
  assign h12_inc = bcd_inc({3'b000, h12});

  always_comb begin
    nxt_o   = cur_i;
    c_min   = 1'b0;
    c_hour  = 1'b0;
    c_day   = 1'b0;
    c_month = 1'b0;
    c_year  = 1'b0;

    if (cur_i.sec == 8'h59) begin
      nxt_o.sec = 8'h00;
      c_min     = 1'b1;
    end else begin
      nxt_o.sec = bcd_inc(cur_i.sec);
    end

    if (c_min) begin
      if (cur_i.min == 8'h59) begin
        nxt_o.min = 8'h00;
        c_hour    = 1'b1;
      end else begin
        nxt_o.min = bcd_inc(cur_i.min);
      end
    end

    if (c_hour) begin
      if (mode12_i) begin
        if (h12 == 5'h12) begin
          nxt_o.hour = {2'b00, pm, 5'h01};
        end else if (h12 == 5'h11) begin
          nxt_o.hour = {2'b00, ~pm, 5'h12};
          c_day      = pm;
        end else begin
          nxt_o.hour = {2'b00, pm, h12_inc[4:0]};
        end
      end else begin
        if (cur_i.hour == 8'h23) begin
          nxt_o.hour = 8'h00;
          c_day      = 1'b1;
        end else begin
          nxt_o.hour = bcd_inc(cur_i.hour);
        end
      end
    end

    if (c_day) begin
      nxt_o.dow = (cur_i.dow == 8'h07) ? 8'h01 : bcd_inc(cur_i.dow);
      if (cur_i.date == last_date(cur_i.month, cur_i.year)) begin
        nxt_o.date = 8'h01;
        c_month    = 1'b1;
      end else begin
        nxt_o.date = bcd_inc(cur_i.date);
      end
    end

    if (c_month) begin
      if (cur_i.month == 8'h12) begin
        nxt_o.month = 8'h01;
        c_year      = 1'b1;
      end else begin
        nxt_o.month = bcd_inc(cur_i.month);
      end
    end

    if (c_year) nxt_o.year = (cur_i.year == 8'h99) ? 8'h00 : bcd_inc(cur_i.year);
  end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic [7:0] nxt_sec_i,
  input  logic [7:0] nxt_min_i,
  input  logic [7:0] nxt_hour_i,
  input  logic [7:0] al_sec_i,
  input  logic [7:0] al_min_i,
  input  logic [7:0] al_hour_i,
  output logic       alarm_o
);
  logic hit;

  assign hit = (nxt_sec_i == al_sec_i) && (nxt_min_i == al_min_i) && (nxt_hour_i == al_hour_i);

  always_ff @(posedge clk) begin
    if (!rst_n) alarm_o <= 1'b0;
    else        alarm_o <= step_i && hit;
  end

  // R10: never two pulses back to back (seconds always move on an advance)
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |=> !alarm_o);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              freeze_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              alarm_o
);
  cal_time_t  cur_q, nxt;
  logic [7:0] al_sec_q, al_min_q, al_hour_q;
  logic       mode12_q;
  logic       step;

  cal_tick_gate #(.PEND_W(PEND_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .freeze_i (freeze_i),
    .hold_i   (wr_en_i),
    .step_o   (step)
  );

  cal_time_step u_step (
    .cur_i    (cur_q),
    .mode12_i (mode12_q),
    .nxt_o    (nxt)
  );

  cal_alarm_cmp u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .nxt_sec_i  (nxt.sec),
    .nxt_min_i  (nxt.min),
    .nxt_hour_i (nxt.hour),
    .al_sec_i   (al_sec_q),
    .al_min_i   (al_min_q),
    .al_hour_i  (al_hour_q),
    .alarm_o    (alarm_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q     <= '{year: 8'h00, month: 8'h01, date: 8'h01, dow: 8'h01,
                     hour: 8'h00, min: 8'h00, sec: 8'h00};
      al_sec_q  <= 8'h00;
      al_min_q  <= 8'h00;
      al_hour_q <= 8'h00;
      mode12_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_W'(A_SEC):   cur_q.sec   <= wdata_i;
        ADDR_W'(A_MIN):   cur_q.min   <= wdata_i;
        ADDR_W'(A_HOUR):  cur_q.hour  <= wdata_i;
        ADDR_W'(A_DOW):   cur_q.dow   <= wdata_i;
        ADDR_W'(A_DATE):  cur_q.date  <= wdata_i;
        ADDR_W'(A_MONTH): cur_q.month <= wdata_i;
        ADDR_W'(A_YEAR):  cur_q.year  <= wdata_i;
        ADDR_W'(A_ASEC):  al_sec_q    <= wdata_i;
        ADDR_W'(A_AMIN):  al_min_q    <= wdata_i;
        ADDR_W'(A_AHOUR): al_hour_q   <= wdata_i;
        ADDR_W'(A_CTRL):  mode12_q    <= wdata_i[0];
        default: ;
      endcase
    end else if (step) begin
      cur_q <= nxt;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(A_SEC):   rdata_o = cur_q.sec;
      ADDR_W'(A_MIN):   rdata_o = cur_q.min;
      ADDR_W'(A_HOUR):  rdata_o = cur_q.hour;
      ADDR_W'(A_DOW):   rdata_o = cur_q.dow;
      ADDR_W'(A_DATE):  rdata_o = cur_q.date;
      ADDR_W'(A_MONTH): rdata_o = cur_q.month;
      ADDR_W'(A_YEAR):  rdata_o = cur_q.year;
      ADDR_W'(A_ASEC):  rdata_o = al_sec_q;
      ADDR_W'(A_AMIN):  rdata_o = al_min_q;
      ADDR_W'(A_AHOUR): rdata_o = al_hour_q;
      ADDR_W'(A_CTRL):  rdata_o = {7'b0, mode12_q};
      default:          rdata_o = 8'h00;
    endcase
  end

  // R8: frozen and not written, nothing moves
  a_r8_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !wr_en_i) |=> $stable(cur_q));

  // R2: an unobstructed tick always moves the seconds
  a_r2_tick_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !freeze_i && !wr_en_i) |=> !$stable(cur_q.sec));

  // R2: seconds wrap from 59 to 00
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en_i && cur_q.sec == 8'h59) |=> (cur_q.sec == 8'h00));

  // R3: 23:59:59 wraps hours to 00 in 24-hour mode
  a_r3_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !mode12_q && cur_q.hour == 8'h23 && cur_q.min == 8'h59 && cur_q.sec == 8'h59)
    |=> (cur_q.hour == 8'h00));

  // R9: a written seconds value is what the register holds next
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_W'(A_SEC)) |=> (cur_q.sec == $past(wdata_i)));

  // R10: a pulse only while time equals the alarm
  a_r10_match: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> (cur_q.sec == al_sec_q && cur_q.min == al_min_q && cur_q.hour == al_hour_q));

endmodule

// File: tb/bcd_calendar_clock_bench.sv
`timescale 1ns/1ps
module bcd_calendar_clock_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, frz = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       alarm;

  int checks = 0, fails = 0;
  logic [7:0] m [16];
  int  pend = 0;
  bit  m_alarm = 0;
  int  ra = 0;

  always #2.5 clk = ~clk;

  bcd_calendar_clock u_bcd_calendar_clock (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .freeze_i(frz), .wr_en_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .alarm_o(alarm)
  );

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic model_reset();
    foreach (m[i]) m[i] = 8'h00;
    m[3] = 8'h01; m[4] = 8'h01; m[5] = 8'h01;
    pend = 0; m_alarm = 0;
  endtask

  task automatic model_advance();
    int s, mi, h, d, mo, y, ml;
    bit pm, dayc;
    dayc = 0;
    s = b2i(m[0]) + 1; mi = b2i(m[1]);
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0;
        if (m[11][0]) begin
          h = b2i(m[2] & 8'h1f); pm = m[2][5];
          if (h == 12) h = 1;
          else if (h == 11) begin h = 12; dayc = pm; pm = !pm; end
          else h++;
          m[2] = {2'b00, pm, 5'(i2b(h))};
        end else begin
          h = b2i(m[2]) + 1;
          if (h == 24) begin h = 0; dayc = 1; end
          m[2] = i2b(h);
        end
      end
    end
    m[0] = i2b(s); m[1] = i2b(mi);
    if (dayc) begin
      m[3] = (m[3] == 8'h07) ? 8'h01 : i2b(b2i(m[3]) + 1);
      d = b2i(m[4]); mo = b2i(m[5]); y = b2i(m[6]);
      if (mo == 2) ml = (y % 4 == 0) ? 29 : 28;
      else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) ml = 30;
      else ml = 31;
      if (d == ml) begin
        d = 1; mo++;
        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
      end else d++;
      m[4] = i2b(d); m[5] = i2b(mo); m[6] = i2b(y);
    end
  endtask

  always @(posedge clk) begin
    bit st;
    if (!rst_n) model_reset();
    else begin
      st = !frz && !wr && (tick || pend != 0);
      if (tick && !st) begin if (pend < 15) pend++; end
      else if (!tick && st) pend--;
      m_alarm = 0;
      if (wr) begin
        if (addr == 4'd11) m[11] = {7'b0, wdata[0]};
        else if (addr != 4'd7 && addr < 4'd11) m[addr] = wdata;
      end else if (st) begin
        model_advance();
        m_alarm = (m[0] == m[8]) && (m[1] == m[9]) && (m[2] == m[10]);
      end
    end
  end

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd1:       return "R2";
      4'd2:             return m[11][0] ? "R4" : "R3";
      4'd3:             return "R5";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd8, 4'd9, 4'd10: return "R10";
      4'd11:            return "R9";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Compare with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(tag_of(addr), rdata, m[addr]);
      check("R10", {7'b0, alarm}, {7'b0, m_alarm});
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1 addr = 4'(ra); ra++; end
  endtask
  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr = 1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 0;
  endtask
  task automatic pulse();
    @(posedge clk); #1 tick = 1;
    @(posedge clk); #1 tick = 0;
    idle(3);
  endtask
  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(posedge clk); #1 addr = a;
    @(negedge clk); check(tag, rdata, exp);
  endtask
  task automatic set_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                          input logic [7:0] dw, input logic [7:0] d, input logic [7:0] mo,
                          input logic [7:0] y);
    wreg(0, s); wreg(1, mi); wreg(2, h); wreg(3, dw); wreg(4, d); wreg(5, mo); wreg(6, y);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(0, 8'h00, "R1"); rd(2, 8'h00, "R1"); rd(3, 8'h01, "R1"); rd(4, 8'h01, "R1");
    rd(5, 8'h01, "R1"); rd(6, 8'h00, "R1"); rd(10, 8'h00, "R1"); rd(11, 8'h00, "R1");
    checks++; if (alarm !== 1'b0) begin fails++; $display("FAIL R1: got alarm %b expected 0", alarm); end

    // R2 plain counting
    pulse(); pulse(); rd(0, 8'h02, "R2");

    // R3 R5 R6: end of non-leap February
    set_time(8'h23, 8'h59, 8'h58, 8'h07, 8'h28, 8'h02, 8'h23);
    pulse(); rd(0, 8'h59, "R2"); pulse();
    rd(2, 8'h00, "R3"); rd(3, 8'h01, "R5"); rd(4, 8'h01, "R6"); rd(5, 8'h03, "R6");

    // R7 leap February
    set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, 8'h24);
    pulse(); rd(4, 8'h29, "R7"); rd(5, 8'h02, "R7");
    wreg(2, 8'h23); wreg(1, 8'h59); wreg(0, 8'h59);
    pulse(); rd(4, 8'h01, "R7"); rd(5, 8'h03, "R7");

    // R6 thirty-day month and year wrap
    set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h30, 8'h04, 8'h10);
    pulse(); rd(4, 8'h01, "R6"); rd(5, 8'h05, "R6");
    set_time(8'h23, 8'h59, 8'h59, 8'h04, 8'h31, 8'h12, 8'h99);
    pulse(); rd(5, 8'h01, "R6"); rd(6, 8'h00, "R6");

    // R4 12-hour mode
    wreg(11, 8'h01);
    set_time(8'h31, 8'h59, 8'h59, 8'h03, 8'h10, 8'h06, 8'h20);
    pulse(); rd(2, 8'h12, "R4"); rd(4, 8'h11, "R4");
    wreg(2, 8'h11); wreg(1, 8'h59); wreg(0, 8'h59);
    pulse(); rd(2, 8'h32, "R4"); rd(4, 8'h11, "R4");
    wreg(1, 8'h59); wreg(0, 8'h59);
    pulse(); rd(2, 8'h21, "R4");
    wreg(11, 8'h00);

    // R8 freeze with pending ticks
    wreg(0, 8'h10);
    @(posedge clk); #1 frz = 1;
    pulse(); pulse(); pulse();
    rd(0, 8'h10, "R8");
    @(posedge clk); #1 frz = 0;
    idle(5); rd(0, 8'h13, "R8");

    // R9 write in a tick cycle defers the tick
    @(posedge clk); #1 wr = 1; addr = 4'd1; wdata = 8'h30; tick = 1;
    @(negedge clk); @(posedge clk); #1 wr = 0; tick = 0;
    @(negedge clk); check("R9", rdata, 8'h30);
    idle(3); rd(0, 8'h14, "R9");

    // R10 alarm
    set_time(8'h10, 8'h20, 8'h28, 8'h02, 8'h05, 8'h05, 8'h05);
    wreg(8, 8'h30); wreg(9, 8'h20); wreg(10, 8'h10);
    pulse();
    @(posedge clk); #1 tick = 1;
    @(posedge clk); #1 tick = 0;
    @(negedge clk); checks++;
    if (alarm !== 1'b1) begin fails++; $display("FAIL R10: got alarm %b expected 1", alarm); end
    @(negedge clk); checks++;
    if (alarm !== 1'b0) begin fails++; $display("FAIL R10: got alarm %b expected 0", alarm); end

    // R11 unmapped address
    wreg(7, 8'h55); rd(7, 8'h00, "R11"); rd(13, 8'h00, "R11");

    // Long run with freeze bursts, model compared every cycle
    for (int k = 0; k < 400; k++) begin
      if (k % 37 == 0) begin @(posedge clk); #1 frz = 1; end
      if (k % 37 == 5) begin @(posedge clk); #1 frz = 0; end
      pulse();
    end
    frz = 0;
    idle(20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule